// File: doc/BRIEF.md
# Relocatable Page Address Generator

This block produces the word address that a CPU with a 16-bit data path places on its 32-bit address bus. Each location on the bus holds one 16-bit word. Direct-page and stack accesses each fall in a 64K-word window. The upper half of the address for each window comes from a page register that software can write, so either window can sit anywhere in the 4G-word space. Absolute accesses pass through unchanged. Vector fetches get fixed addresses at the very top of the space.

Each cycle the core presents an access kind, a 16-bit offset or stack pointer, a full absolute address and a vector select. The block returns the selected address, registered, on the following cycle. The core writes the two page registers with strobes over a shared 16-bit data bus. It reads them back through dedicated outputs, so any accumulator can be copied to or from a page register.

Top module: `page_addr_gen`

## Requirements
- R1: While reset is high, and on the cycle after reset is released, the direct-page register reads 0x0000, the stack-page register reads 0x0001 and the address output is 0x0000_0000.
- R2: An access with kind 2'b00 (direct page) yields, one clock later, the address {direct-page register, offset}, using the register value held during the access cycle.
- R3: An access with kind 2'b01 (stack) yields, one clock later, the address {stack-page register, offset}.
- R4: An access with kind 2'b10 (absolute) yields, one clock later, the 32-bit absolute address input unchanged.
- R5: An access with kind 2'b11 (vector) yields, one clock later, 0xFFFF_FFFA for select 0 (non-maskable interrupt), 0xFFFF_FFFC for select 1 (reset) and 0xFFFF_FFFE for select 2 or 3 (maskable interrupt), plus 1 when the high-word input is set.
- R6: A load strobe writes the load data into its page register at the clock edge. The readback output shows the new value after that edge. An access in the same cycle as the strobe still uses the old value, and the next access uses the new one.
- R7: A page register with no load strobe keeps its value. A strobe for one page register leaves the other unchanged. Asserting both strobes writes the same data to both.
- R8: Offset 0xFFFF maps to the last word of the current window. The carry never reaches the page half, so 0x00FF with 0xFFFF gives 0x00FF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | 00 direct page, 01 stack, 10 absolute, 11 vector |
| ofs | input | 16 | Direct-page offset or stack pointer |
| abs_addr | input | 32 | Absolute address |
| vec_sel | input | 2 | 0 NMI, 1 reset, 2/3 IRQ |
| vec_hi | input | 1 | Selects the high word of the vector |
| dp_load | input | 1 | Write strobe for the direct-page register |
| sp_load | input | 1 | Write strobe for the stack-page register |
| load_data | input | 16 | Value to write into the page register(s) |
| addr | output | 32 | Registered bus address |
| dp_page | output | 16 | Current direct-page register |
| sp_page | output | 16 | Current stack-page register |

## Verification
Every result lands exactly one clock after its stimulus. The address is taken from the inputs and page registers of the cycle before, and a readback output shows a load right after the edge that carried the strobe. The bench drives inputs on the falling edge and checks on the next falling edge, one rising edge later. Its page-register model is updated only after the expected address has been formed from the old values, so same-cycle load and access are covered. A long mixed sweep exercises all four kinds with interleaved loads, alongside directed vector, wrap and hold cases.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [1:0] {
    KIND_DP  = 2'd0,
    KIND_STK = 2'd1,
    KIND_ABS = 2'd2,
    KIND_VEC = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/page_reg.sv
module page_reg #(
  parameter int              W       = 16,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/vec_addr.sv
module vec_addr #(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        sel,
  input  logic              hi,
  output logic [ADDR_W-1:0] addr
);
  logic [1:0] sel_eff;
  logic [3:0] low;

  always_comb begin
    sel_eff = (sel == 2'd3) ? 2'd2 : sel;
    low     = 4'hA + {1'b0, sel_eff, 1'b0} + {3'b000, hi};
    addr    = {{(ADDR_W-4){1'b1}}, low};
  end
endmodule

// File: rtl/page_addr_gen.sv
module page_addr_gen
  import pag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int DP_RST = 0,
  parameter int SP_RST = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              acc_kind,
  input  logic [OFS_W-1:0]        ofs,
  input  logic [ADDR_W-1:0]       abs_addr,
  input  logic [1:0]              vec_sel,
  input  logic                    vec_hi,
  input  logic                    dp_load,
  input  logic                    sp_load,
  input  logic [ADDR_W-OFS_W-1:0] load_data,
  output logic [ADDR_W-1:0]       addr,
  output logic [ADDR_W-OFS_W-1:0] dp_page,
  output logic [ADDR_W-OFS_W-1:0] sp_page
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] vec_a;
  logic [ADDR_W-1:0] next_addr;
  acc_kind_e         kind;

  page_reg #(.W(PAGE_W), .RST_VAL(PAGE_W'(DP_RST))) i_dp_reg (
    .clk(clk), .rst(rst), .ld(dp_load), .d(load_data), .q(dp_page)
  );

  page_reg #(.W(PAGE_W), .RST_VAL(PAGE_W'(SP_RST))) i_sp_reg (
    .clk(clk), .rst(rst), .ld(sp_load), .d(load_data), .q(sp_page)
  );

  vec_addr #(.ADDR_W(ADDR_W)) i_vec (
    .sel(vec_sel), .hi(vec_hi), .addr(vec_a)
  );

  always_comb begin
    kind = acc_kind_e'(acc_kind);
    unique case (kind)
      KIND_DP:  next_addr = {dp_page, ofs};
      KIND_STK: next_addr = {sp_page, ofs};
      KIND_ABS: next_addr = abs_addr;
      default:  next_addr = vec_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) addr <= '0;
    else     addr <= next_addr;
  end
endmodule

// File: rtl/page_addr_gen_chk.sv
module page_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              acc_kind,
  input logic [OFS_W-1:0]        ofs,
  input logic [ADDR_W-1:0]       abs_addr,
  input logic [1:0]              vec_sel,
  input logic                    vec_hi,
  input logic                    dp_load,
  input logic                    sp_load,
  input logic [ADDR_W-OFS_W-1:0] load_data,
  input logic [ADDR_W-1:0]       addr,
  input logic [ADDR_W-OFS_W-1:0] dp_page,
  input logic [ADDR_W-OFS_W-1:0] sp_page
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dp_page == '0 && sp_page == 1 && addr == '0));

  // R2
  dp_concat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_kind) == 2'd0) |->
      (addr[ADDR_W-1:OFS_W] == $past(dp_page) && addr[OFS_W-1:0] == $past(ofs)));

  // R3
  sp_concat_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_kind) == 2'd1) |->
      (addr[ADDR_W-1:OFS_W] == $past(sp_page) && addr[OFS_W-1:0] == $past(ofs)));

  // R4
  abs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_kind) == 2'd2) |-> (addr == $past(abs_addr)));

  // R5
  vec_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_kind) == 2'd3) |->
      (&addr[ADDR_W-1:3] && addr[0] == $past(vec_hi) &&
       addr[2:1] == (($past(vec_sel) == 2'd0) ? 2'b01 :
                     ($past(vec_sel) == 2'd1) ? 2'b10 : 2'b11)));

  // R6
  dp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dp_load)) |-> (dp_page == $past(load_data)));

  // R6
  sp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sp_load)) |-> (sp_page == $past(load_data)));

  // R7
  dp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dp_load)) |-> $stable(dp_page));

  // R7
  sp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sp_load)) |-> $stable(sp_page));
endmodule

bind page_addr_gen page_addr_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_chk (.*);

// File: tb/test_page_addr_gen.sv
module test_page_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_kind = 2'd0;
  logic [15:0] ofs = '0;
  logic [31:0] abs_addr = '0;
  logic [1:0]  vec_sel = '0;
  logic        vec_hi = 1'b0;
  logic        dp_load = 1'b0;
  logic        sp_load = 1'b0;
  logic [15:0] load_data = '0;
  logic [31:0] addr;
  logic [15:0] dp_page, sp_page;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [15:0] m_dp, m_sp;
  logic [31:0] x;

  always #10 clk = ~clk;

  page_addr_gen i_page_addr_gen (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .ofs(ofs), .abs_addr(abs_addr),
    .vec_sel(vec_sel), .vec_hi(vec_hi), .dp_load(dp_load), .sp_load(sp_load),
    .load_data(load_data), .addr(addr), .dp_page(dp_page), .sp_page(sp_page)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] vec_exp(logic [1:0] s, logic h);
    int idx = (s > 2'd2) ? 2 : int'(s);
    return 32'hFFFF_FFFA + 32'(2 * idx) + 32'(h);
  endfunction

  function automatic logic [31:0] exp_addr(logic [1:0] k);
    case (k)
      2'd0:    return {m_dp, ofs};
      2'd1:    return {m_sp, ofs};
      2'd2:    return abs_addr;
      default: return vec_exp(vec_sel, vec_hi);
    endcase
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    @(negedge clk);
    tick(); tick();
    // R1: state while in reset
    chk("R1 dp_page", 32'(dp_page), 32'h0);
    chk("R1 sp_page", 32'(sp_page), 32'h1);
    chk("R1 addr", addr, 32'h0);
    rst = 1'b0;
    acc_kind = 2'd0; ofs = 16'h0042;
    tick();
    m_dp = 16'h0000; m_sp = 16'h0001;
    chk("R1 dp_page after release", 32'(dp_page), 32'h0);
    chk("R2 default direct page", addr, 32'h0000_0042);

    // R5: every vector select and word half
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 2; h++) begin
        acc_kind = 2'd3; vec_sel = 2'(s); vec_hi = 1'(h);
        tick();
        chk("R5 vector", addr, vec_exp(2'(s), 1'(h)));
      end
    end

    // R3: default stack page
    acc_kind = 2'd1; ofs = 16'h01FF;
    tick();
    chk("R3 default stack", addr, 32'h0001_01FF);

    // R6: load with same-cycle access uses old page, then the new one
    acc_kind = 2'd0; ofs = 16'h0005; dp_load = 1'b1; load_data = 16'h1234;
    tick();
    dp_load = 1'b0;
    chk("R6 same-cycle old page", addr, 32'h0000_0005);
    chk("R6 readback", 32'(dp_page), 32'h1234);
    chk("R7 other page untouched", 32'(sp_page), 32'h0001);
    tick();
    chk("R6 next access new page", addr, 32'h1234_0005);
    m_dp = 16'h1234;

    // R7: both strobes write the same value
    dp_load = 1'b1; sp_load = 1'b1; load_data = 16'h00FF; acc_kind = 2'd1; ofs = 16'h0010;
    tick();
    dp_load = 1'b0; sp_load = 1'b0;
    chk("R7 both dp", 32'(dp_page), 32'h00FF);
    chk("R7 both sp", 32'(sp_page), 32'h00FF);
    chk("R3 old stack page", addr, 32'h0001_0010);
    m_dp = 16'h00FF; m_sp = 16'h00FF;

    // R8: offset at top of window stays inside the page
    acc_kind = 2'd0; ofs = 16'hFFFF;
    tick();
    chk("R8 dp wrap", addr, 32'h00FF_FFFF);
    sp_load = 1'b1; load_data = 16'hFFFF; acc_kind = 2'd2; abs_addr = 32'hDEAD_BEEF;
    tick();
    sp_load = 1'b0; m_sp = 16'hFFFF;
    chk("R4 absolute", addr, 32'hDEAD_BEEF);
    acc_kind = 2'd1; ofs = 16'hFFFF;
    tick();
    chk("R8 sp wrap", addr, 32'hFFFF_FFFF);

    // R7: hold with no strobes
    for (int i = 0; i < 4; i++) begin
      load_data = 16'(16'hA5A5 + i);
      tick();
      chk("R7 hold dp", 32'(dp_page), 32'(m_dp));
      chk("R7 hold sp", 32'(sp_page), 32'(m_sp));
    end

    // R2 R3 R4 R5 R6: mixed sweep with interleaved loads
    x = 32'h1357_9BDF;
    for (int i = 0; i < 2000; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      acc_kind  = 2'(i % 4);
      ofs       = x[15:0];
      abs_addr  = {x[7:0], x[31:8]};
      vec_sel   = x[17:16];
      vec_hi    = x[18];
      load_data = x[31:16];
      dp_load   = (i % 7 == 3);
      sp_load   = (i % 5 == 1);
      e = exp_addr(acc_kind);
      if (dp_load) m_dp = load_data;
      if (sp_load) m_sp = load_data;
      tick();
      case (i % 4)
        0:       chk("R2 sweep", addr, e);
        1:       chk("R3 sweep", addr, e);
        2:       chk("R4 sweep", addr, e);
        default: chk("R5 sweep", addr, e);
      endcase
      chk("R6 sweep dp", 32'(dp_page), 32'(m_dp));
      chk("R6 sweep sp", 32'(sp_page), 32'(m_sp));
    end
    dp_load = 1'b0; sp_load = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule